// File: doc/BRIEF.md
# Carry-Bypass Adder

A purely combinational 16-bit binary adder. It takes two operands and a carry-in and returns their sum together with the carry-out. The operand width is divided into four equal 4-bit groups. Each group works out, for every bit, whether the bit generates a carry, kills it, or passes it on. Inside the group the carry then ripples from bit to bit.

Each group also ANDs its four pass-on flags into a skip signal. When that signal is high, a multiplexer sends the group's incoming carry straight to its outgoing carry and the ripple chain is not used. A carry that enters at the bottom can therefore cross any run of groups that pass it on, using one multiplexer per group. The carry-out of the top group's multiplexer is the carry-out of the adder.

The adder has no registers. It is meant to sit between pipeline registers that belong to the surrounding datapath.

Top module: `cba_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, for every input combination.
- R2: `cout_o` equals bit 16 of the 17-bit result of `a_i + b_i + cin_i`.
- R3: Each bit is classed as exactly one of three kinds. It generates when both operand bits are 1. It passes on when exactly one operand bit is 1. It kills when both are 0. A bit that generates sends out a carry of 1, and a bit that kills sends out 0, whatever carry comes in.
- R4: When all four bits of a group pass on, the group's carry-out equals its carry-in. For example, `a_i = ~b_i` with `cin_i = 1` gives `sum_o = 0x0000` and `cout_o = 1`, and with `cin_i = 0` gives `sum_o = 0xFFFF` and `cout_o = 0`.
- R5: Inside a group the carry moves one bit at a time: the carry out of bit i is the carry into bit i+1. The group's carry-out is the carry out of its bit 3 whenever the group is not skipped.
- R6: Group 0 takes `cin_i`. Group k (bits 4k+3..4k) takes the carry-out of group k-1. `cout_o` is the carry-out of group 3.
- R7: Sum bit i is the XOR of the two operand bits and the carry into bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum, modulo 2^16 |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The skip path and the ripple path can both be active in the same evaluation. One group may forward its carry through the multiplexer while the group above it generates or kills that carry through its own chain. A group that fully passes on can also have its ripple chain reach the same value that its multiplexer chooses. Directed vectors build these mixtures: a low group that generates, one or more middle groups made all pass-on with `a = ~b`, and a top group that absorbs the carry. Random vectors add other combinations. Every result is judged against the bench's own 17-bit reference sum. The per-group checks also confirm, whenever a skip is taken, that the ripple chain agrees with the multiplexer.

// File: rtl/cba_pkg.sv
package cba_pkg;

  // Classification of one bit position for carry handling.
  typedef struct packed {
    logic gen;   // both operand bits set
    logic prop;  // exactly one operand bit set
    logic kill;  // both operand bits clear
  } bit_class_t;

  localparam int unsigned DEF_WIDTH = 16;
  localparam int unsigned DEF_GROUP = 4;

endpackage

// File: rtl/cba_pg_cell.sv
module cba_pg_cell
  import cba_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  output bit_class_t cls_o
);

  always_comb begin
    cls_o.gen  = a_i & b_i;
    cls_o.prop = a_i ^ b_i;
    cls_o.kill = ~(a_i | b_i);
  end

  // R3: a bit falls into exactly one class.
  always_comb begin
    p_one_class_r3: assert ($onehot({cls_o.gen, cls_o.prop, cls_o.kill}))
      else $error("bit class not one-hot");
  end

endmodule

// File: rtl/cba_group.sv
module cba_group
  import cba_pkg::*;
#(
  parameter int unsigned GW = DEF_GROUP
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          cout_o
);

  bit_class_t        cls [GW];
  logic [GW-1:0]     prop_vec;
  logic [GW:0]       chain;
  logic              ripple_out;
  logic              skip;

  // Per-bit generate / propagate / kill classification.
  for (genvar i = 0; i < GW; i++) begin : g_bit
    cba_pg_cell u_cell (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .cls_o (cls[i])
    );
    assign prop_vec[i] = cls[i].prop;
  end

  // Ripple chain: kill forces 0, generate forces 1, otherwise pass on.
  always_comb begin
    chain[0] = cin_i;
    for (int i = 0; i < GW; i++) begin
      if (cls[i].kill)
        chain[i+1] = 1'b0;
      else if (cls[i].gen)
        chain[i+1] = 1'b1;
      else
        chain[i+1] = chain[i];
    end
  end

  assign ripple_out = chain[GW];

  // Group-wide skip and bypass multiplexer.
  assign skip   = &prop_vec;
  assign cout_o = skip ? cin_i : ripple_out;

  // Sum per bit.
  assign sum_o  = prop_vec ^ chain[GW-1:0];

  // R4: when the skip is taken the ripple chain reaches the same carry.
  always_comb begin
    if (skip) begin
      p_skip_matches_ripple_r4: assert (ripple_out == cin_i)
        else $error("ripple chain disagrees with skip path");
    end
  end

  // R5: group result equals the arithmetic sum of its slice.
  always_comb begin
    p_group_arith_r5: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{GW{1'b0}}, cin_i}))
      else $error("group slice sum mismatch");
  end

endmodule

// File: rtl/cba_adder.sv
module cba_adder
  import cba_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned GROUP = DEF_GROUP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int unsigned NGRP = WIDTH / GROUP;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    logic ci;
    logic co;

    if (k == 0) begin : g_first
      assign ci = cin_i;
    end else begin : g_next
      assign ci = g_grp[k-1].co;
    end

    cba_group #(.GW(GROUP)) u_group (
      .a_i    (a_i[k*GROUP +: GROUP]),
      .b_i    (b_i[k*GROUP +: GROUP]),
      .cin_i  (ci),
      .sum_o  (sum_o[k*GROUP +: GROUP]),
      .cout_o (co)
    );
  end

  assign cout_o = g_grp[NGRP-1].co;

  // R1 / R2: full-width result matches arithmetic addition.
  always_comb begin
    p_full_sum_r1: assert (sum_o ==
        WIDTH'(({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})))
      else $error("sum mismatch");
    p_carry_out_r2: assert (cout_o ==
        ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}) >> WIDTH)
      else $error("carry-out mismatch");
  end

endmodule

// File: tb/cba_adder_tb.sv
module cba_adder_tb;

  localparam int unsigned W = 16;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;

  cba_adder u_dut (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [W:0] ref_add(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic apply_check(input logic [W-1:0] x, input logic [W-1:0] y,
                             input logic c, input string req);
    logic [W:0] exp;
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
    exp = ref_add(x, y, c);
    n_checks++;
    if ({cout, sum} !== exp) begin
      n_errors++;
      $display("FAIL %s: a=%h b=%h cin=%b actual cout=%b sum=%h expected cout=%b sum=%h",
               req, x, y, c, cout, sum, exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    int unsigned seed_v;
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state inputs: all zero gives zero result (R1, R2).
    apply_check(16'h0000, 16'h0000, 1'b0, "R1");

    // Full propagation through all groups (R4).
    apply_check(16'hA5C3, 16'h5A3C, 1'b1, "R4");
    apply_check(16'hA5C3, 16'h5A3C, 1'b0, "R4");
    apply_check(16'hFFFF, 16'h0000, 1'b1, "R4");

    // All generate / all kill (R3).
    apply_check(16'hFFFF, 16'hFFFF, 1'b0, "R3");
    apply_check(16'h0000, 16'h0000, 1'b1, "R3");
    apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R3");

    // Ripple within one group (R5, R7).
    apply_check(16'h0007, 16'h0001, 1'b0, "R5");
    apply_check(16'h0005, 16'h000A, 1'b1, "R7");
    apply_check(16'h0070, 16'h0010, 1'b1, "R5");

    // Carry crossing skipped middle groups into the top (R6, R2).
    apply_check(16'h0FF8, 16'h0008, 1'b0, "R6");
    apply_check(16'h00F1, 16'h0F0F, 1'b1, "R6");
    apply_check(16'hF0F8, 16'h0F08, 1'b0, "R2");
    apply_check(16'h8000, 16'h8000, 1'b0, "R2");

    // Random mixtures (R1, R2).
    seed_v = $urandom(32'd20240611);
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      // Every fourth vector forces some groups to fully propagate.
      if ((i % 4) == 0) y = ~x ^ (W'($urandom) & 16'hF00F);
      apply_check(x, y, 1'($urandom), "R1");
    end

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule